// File: doc/BRIEF.md
# Bus Suspend and Wake Controller

This block sets the power state of a host-attached serial bridge. It watches a host-side activity strobe and counts consecutive idle cycles of the 12 MHz timebase. Once the idle run reaches a fixed limit (3 ms, 36000 cycles, by default), it parks the device in suspend, gates the functional clock off and drops the ready flag.

Two events bring the device back. A host resume returns it to full operation on the next clock edge. A falling edge on the two-wire serial pins also wakes it. Which pins count depends on the bridge role: in master role only the clock line wakes the device, while in slave role either the clock or the data line does. The pin inputs pass through synchronisers, and their edge detector responds only while the device is suspended.

A pin wake first reopens the clock and runs a short start-up delay (16 cycles) before ready returns. If the remote-wake feature is enabled, the block then drives a single fixed-length request pulse toward the host. After the pulse it holds ready low until the host answers with resume.

Top module: `link_power_ctrl`

## Requirements
- R1: During and straight after reset the block is in the running state: `suspended`=0, `clk_en`=1, `ready`=1, `rwake_req`=0.
- R2: After IDLE_CYCLES consecutive rising clock edges that sample `bus_active`=0 while running, the block is suspended: `suspended`=1, `clk_en`=0, `ready`=0. One edge fewer leaves it running.
- R3: Any edge that samples `bus_active`=1 while running restarts the idle count from zero.
- R4: `host_resume`=1 sampled while suspended, or while waiting for the host after a remote-wake request, gives `ready`=1 and `suspended`=0 after that one edge, with no start-up delay.
- R5: With `slave_mode`=0 (master role), a falling edge on `scl_in` wakes the device, and a falling edge on `sda_in` leaves it suspended.
- R6: With `slave_mode`=1 (slave role), a falling edge on either `scl_in` or `sda_in` wakes the device.
- R7: A pin fall leaves `suspended` at 1 for two edges after it and clears it at the third. From that edge `clk_en`=1 and `ready`=0 for STARTUP_CYCLES cycles. With `rwake_en`=0, `ready` then returns to 1.
- R8: With `rwake_en`=1 at the end of start-up, `rwake_req` is 1 for exactly RWAKE_PULSE cycles. After the pulse, `ready` stays 0 until `host_resume` is sampled.
- R9: Pin edges that occur while the device is not suspended are ignored: neither a fall during operation nor a rising edge while suspended wakes the device later.
- R10: `rwake_req` is never 1 while `rwake_en` is 0.
- R11: `ready` and `suspended` are never both 1, and `clk_en` is 0 exactly while `suspended` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz timebase |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_active | input | 1 | Host bus activity seen this cycle |
| host_resume | input | 1 | Host resume signalling detected |
| scl_in | input | 1 | Serial clock pin level (asynchronous) |
| sda_in | input | 1 | Serial data pin level (asynchronous) |
| slave_mode | input | 1 | 1 = slave role, 0 = master role |
| rwake_en | input | 1 | Remote-wake request enable |
| suspended | output | 1 | Device is in suspend |
| clk_en | output | 1 | Functional clock enable |
| ready | output | 1 | Device is operational |
| rwake_req | output | 1 | Remote-wake request pulse toward the host |

## Verification
The bench builds the block with IDLE_CYCLES=20, STARTUP_CYCLES=16 and RWAKE_PULSE=4. The short idle limit lets each suspend be reached in a few dozen cycles, so every role, wake pin and remote-wake combination gets its own suspend and wake round. The idle boundary is probed one edge either side of the limit. The start-up delay keeps its real length, so the 16-cycle window and the request pulse are checked edge by edge.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SUSP = 3'd1,
    ST_BOOT = 3'd2,
    ST_PING = 3'd3,
    ST_HOLD = 3'd4
  } pwr_state_e;

  // true when a zero-based count sits on the final cycle of a window
  function automatic logic final_tick(input int unsigned cnt, input int unsigned span);
    return (cnt + 1) == span;
  endfunction

  // pin falls that qualify as a wake source for the current role
  function automatic logic wake_source(input logic scl_fall, input logic sda_fall,
                                       input logic slave_role);
    return scl_fall | (slave_role & sda_fall);
  endfunction

  function automatic int unsigned count_width(input int unsigned span);
    return (span < 2) ? 1 : $clog2(span);
  endfunction

endpackage

// File: rtl/pwr_edge_sync.sv
`timescale 1ns/1ps
module pwr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= pin;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b1;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= chain[STAGES-1];
  end

  assign fall = last_q & ~chain[STAGES-1];

endmodule

// File: rtl/pwr_window_timer.sv
`timescale 1ns/1ps
module pwr_window_timer
  import pwr_pkg::*;
#(
  parameter int unsigned SPAN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);

  localparam int unsigned CW = count_width(SPAN);

  logic [CW-1:0] cnt_q;

  assign done = run & ~clear & final_tick(32'(cnt_q), SPAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (done)   cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/link_power_ctrl.sv
`timescale 1ns/1ps
module link_power_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned IDLE_CYCLES    = 36000,
  parameter int unsigned STARTUP_CYCLES = 16,
  parameter int unsigned RWAKE_PULSE    = 12,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_active,
  input  logic host_resume,
  input  logic scl_in,
  input  logic sda_in,
  input  logic slave_mode,
  input  logic rwake_en,
  output logic suspended,
  output logic clk_en,
  output logic ready,
  output logic rwake_req
);

  localparam int unsigned NPINS = 2;

  pwr_state_e state_q, state_d;

  // named internal events
  logic [NPINS-1:0] pin_lvl;
  logic [NPINS-1:0] pin_fall;
  logic             pin_wake;
  logic             idle_done;
  logic             boot_done;
  logic             ping_done;
  logic             in_run, in_susp, in_boot, in_ping;

  assign pin_lvl = {sda_in, scl_in};

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pwr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (pin_lvl[p]),
        .fall  (pin_fall[p])
      );
    end
  endgenerate

  assign in_run  = (state_q == ST_RUN);
  assign in_susp = (state_q == ST_SUSP);
  assign in_boot = (state_q == ST_BOOT);
  assign in_ping = (state_q == ST_PING);

  // armed only while suspended
  assign pin_wake = in_susp & wake_source(pin_fall[0], pin_fall[1], slave_mode);

  pwr_window_timer #(.SPAN(IDLE_CYCLES)) u_idle (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~in_run | bus_active),
    .run   (in_run & ~bus_active),
    .done  (idle_done)
  );

  pwr_window_timer #(.SPAN(STARTUP_CYCLES)) u_boot (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~in_boot),
    .run   (in_boot),
    .done  (boot_done)
  );

  pwr_window_timer #(.SPAN(RWAKE_PULSE)) u_ping (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (~in_ping | host_resume),
    .run   (in_ping),
    .done  (ping_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:  if (idle_done) state_d = ST_SUSP;
      ST_SUSP: begin
        if (host_resume)   state_d = ST_RUN;
        else if (pin_wake) state_d = ST_BOOT;
      end
      ST_BOOT: if (boot_done) state_d = rwake_en ? ST_PING : ST_RUN;
      ST_PING: begin
        if (host_resume)    state_d = ST_RUN;
        else if (ping_done) state_d = ST_HOLD;
      end
      ST_HOLD: if (host_resume) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign suspended = in_susp;
  assign clk_en    = ~in_susp;
  assign ready     = in_run;
  assign rwake_req = in_ping;

endmodule

// File: rtl/link_power_ctrl_chk.sv
`timescale 1ns/1ps
module link_power_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_active,
  input logic host_resume,
  input logic rwake_en,
  input logic pin_wake,
  input logic suspended,
  input logic clk_en,
  input logic ready,
  input logic rwake_req
);

  assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (!suspended && clk_en));

  assert_clk_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !clk_en);

  assert_enter_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(!bus_active));

  assert_resume_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && host_resume) |=> (ready && !suspended));

  assert_pin_boot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && !host_resume && pin_wake) |=> (!suspended && !ready && clk_en));

  assert_rwake_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rwake_req) |-> $past(rwake_en));

  assert_ping_awake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rwake_req |-> (!ready && !suspended));

endmodule

bind link_power_ctrl link_power_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_active  (bus_active),
  .host_resume (host_resume),
  .rwake_en    (rwake_en),
  .pin_wake    (pin_wake),
  .suspended   (suspended),
  .clk_en      (clk_en),
  .ready       (ready),
  .rwake_req   (rwake_req)
);

// File: tb/tb_link_power_ctrl.sv
`timescale 1ns/1ps
module tb_link_power_ctrl;

  localparam int unsigned IDLE  = 20;
  localparam int unsigned BOOT  = 16;
  localparam int unsigned PULSE = 4;

  // vector bits: {slave_mode, rwake_en, use_sda, expect_wake}
  localparam logic [3:0] VEC [8] = '{
    4'b0001, 4'b0010, 4'b1001, 4'b1011,
    4'b0101, 4'b1111, 4'b0110, 4'b1101
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_active = 1'b1, host_resume = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic slave_mode = 1'b0, rwake_en = 1'b0;
  logic suspended, clk_en, ready, rwake_req;

  int checks = 0;
  int fails = 0;
  int stray_req = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  link_power_ctrl #(
    .IDLE_CYCLES(IDLE), .STARTUP_CYCLES(BOOT), .RWAKE_PULSE(PULSE), .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .bus_active(bus_active), .host_resume(host_resume),
    .scl_in(scl_in), .sda_in(sda_in), .slave_mode(slave_mode), .rwake_en(rwake_en),
    .suspended(suspended), .clk_en(clk_en), .ready(ready), .rwake_req(rwake_req)
  );

  // R10 / R11 monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (rwake_req && !rwake_en) stray_req++;
      if ((ready && suspended) || (clk_en == suspended)) stray_req++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    bus_active = 1'b0;
    tick(IDLE);
    chk("R2 suspend", {29'd0, suspended, clk_en, ready}, 32'b100);
  endtask

  task automatic resume_now(input string req);
    host_resume = 1'b1;
    tick(1);
    host_resume = 1'b0;
    chk(req, {30'd0, ready, suspended}, 32'b10);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", {28'd0, suspended, clk_en, ready, rwake_req}, 32'b0110);
    rst_n = 1'b1;
    tick(1);
    chk("R1 after reset", {28'd0, suspended, clk_en, ready, rwake_req}, 32'b0110);

    // R2 boundary and R3 restart
    bus_active = 1'b0;
    tick(IDLE - 1);
    chk("R2 one short", {31'd0, suspended}, 0);
    bus_active = 1'b1;
    tick(1);
    bus_active = 1'b0;
    tick(IDLE - 1);
    chk("R3 restart", {31'd0, suspended}, 0);
    tick(1);
    chk("R2 at limit", {29'd0, suspended, clk_en, ready}, 32'b100);

    // R4 host resume
    resume_now("R4 resume");
    bus_active = 1'b1;

    // R9 fall during run ignored
    scl_in = 1'b0;
    tick(4);
    go_idle();
    tick(6);
    chk("R9 stale fall", {31'd0, suspended}, 1);
    scl_in = 1'b1;
    tick(5);
    chk("R9 rising edge", {31'd0, suspended}, 1);
    resume_now("R4 resume");
    bus_active = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [3:0] v;
      v = VEC[i];
      slave_mode = v[3];
      rwake_en   = v[2];
      tick(2);
      go_idle();
      if (v[1]) sda_in = 1'b0; else scl_in = 1'b0;
      tick(2);
      chk("R7 sync delay", {31'd0, suspended}, 1);
      tick(1);
      chk(v[3] ? "R6 slave wake" : "R5 master wake", {31'd0, suspended}, {31'd0, ~v[0]});
      if (v[0]) begin
        chk("R7 boot", {30'd0, clk_en, ready}, 32'b10);
        tick(BOOT - 1);
        chk("R7 boot end", {30'd0, clk_en, ready}, 32'b10);
        tick(1);
        if (v[2]) begin
          chk("R8 pulse start", {30'd0, rwake_req, ready}, 32'b10);
          tick(PULSE - 1);
          chk("R8 pulse last", {31'd0, rwake_req}, 1);
          tick(1);
          chk("R8 pulse over", {30'd0, rwake_req, ready}, 32'b00);
          tick(5);
          chk("R8 hold", {30'd0, ready, suspended}, 32'b00);
          resume_now("R8 resume");
        end else begin
          chk("R7 ready", {30'd0, rwake_req, ready}, 32'b01);
        end
      end else begin
        tick(6);
        chk("R5 sda ignored", {31'd0, suspended}, 1);
        resume_now("R4 resume");
      end
      scl_in = 1'b1;
      sda_in = 1'b1;
      bus_active = 1'b1;
    end

    chk("R10 R11 monitor", stray_req, 0);
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

endmodule